// File: doc/BRIEF.md
# SPI Serial Clock Prescaler with Two Field Encodings

This block turns the core clock into the serial clock of an SPI master. It also produces two single-cycle strobes for the shift engine that sits beside it. A prescale field from the configuration register selects the divide ratio. A build-time parameter selects one of two field layouts. The legacy layout allows only even ratios from 4 to 30. The extended layout multiplies a four-bit mantissa by a power of two, which reaches ratios up to 1920. Every field value maps to a defined ratio, including values the layout does not define.

A transfer starts when `run` is raised while the block is idle. At that moment the block latches the divisor, CPOL, CPHA and the sample-timing choice. It then toggles SCK until `run` is low at a point where SCK sits at its CPOL level. While idle, SCK follows CPOL. The launch strobe marks the edge on which the shift engine drives its next bit. The sample strobe marks the cycle in which it captures MISO. The sample strobe can be moved one core cycle later, for fast clocks with long return paths, such as a 50 MHz SCK from a 250 MHz core clock with CPOL and CPHA both 1.

Top module: `spi_sck_prescaler`

## Requirements
- R1: While reset is asserted and after it is released with CPOL 0, SCK, the launch strobe and the sample strobe are all 0.
- R2: With ENCODING=0, for a field whose low five bits v are 0x12 or more, the divisor is 2*(v-16): an even value from 4 to 30.
- R3: With ENCODING=0, a low five-bit value below 0x12 gives divisor 4, and field bits [7:5] have no effect.
- R4: With ENCODING=1, the divisor is m*2^e. Here m is field bits [3:0]. e is a 3-bit value whose bit 0 comes from field bit 4 and whose bits [2:1] come from field bits [7:6]. Field bit 5 has no effect. Field 0xDF gives 1920.
- R5: With ENCODING=1, a mantissa of 0 or 1 gives divisor 2 whatever the exponent, so SCK never stops and never runs at the core rate.
- R6: For a divisor d, SCK stays high for floor(d/2) core cycles and low for d-floor(d/2) cycles. This holds for either CPOL, so for an odd d the high phase is one cycle shorter.
- R7: While no transfer is active, SCK equals CPOL one cycle later.
- R8: A change of the prescale field during a transfer has no effect on that transfer. The new divisor applies from the next transfer.
- R9: An edge leaving the CPOL level is the leading edge, and an edge returning to it is the trailing edge. With CPHA 0 the sample strobe pulses in the cycle SCK shows a leading edge and the launch strobe pulses on a trailing edge. With CPHA 1 the roles swap. No strobe pulses in other cycles.
- R10: Sample-timing values 2 and 3 delay the sample strobe by one core cycle. Values 0 and 1 leave it aligned with its edge.
- R11: After `run` falls, SCK completes its current period, rests at the CPOL level, and toggles no further. A transfer whose request drops before the first leading edge produces no edge at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Transfer request; rising while idle starts a transfer |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase: selects which edge samples |
| prescale_field | input | 8 | Prescale field, decoded per ENCODING |
| tmiso_sel | input | 2 | MISO sample-timing field |
| sck | output | 1 | Serial clock |
| launch_stb | output | 1 | One-cycle pulse: drive next output bit |
| sample_stb | output | 1 | One-cycle pulse: capture MISO |

## Verification
The bench builds two copies side by side from the same stimulus: one with ENCODING=1 and one with ENCODING=0. Each field value therefore exercises both decoders at once, and one stimulus sets a legal ratio in one layout and an undefined one in the other. The extended copy reaches odd ratios, the divisor-2 floor, the split exponent bits and the 1920 maximum. The legacy copy covers clamping of short fields and the ignored upper bits.

// File: rtl/spi_pscl_pkg.sv
package spi_pscl_pkg;

  localparam int PSC_FIELD_W = 8;
  localparam int PSC_DIV_W   = 11;
  localparam int PSC_TMISO_W = 2;

  localparam int ENC_LEGACY   = 0;
  localparam int ENC_EXTENDED = 1;

  // Configuration captured when a transfer starts.
  typedef struct packed {
    logic cpha;
    logic late_sample;
  } xfer_cfg_t;

  // Legacy layout: even ratios 4..30 from field = 0x10 + ratio/2.
  // Short values clamp to the smallest ratio.
  function automatic logic [PSC_DIV_W-1:0] psc_legacy_div(
    input logic [PSC_FIELD_W-1:0] f
  );
    logic [4:0] v;
    v = f[4:0];
    if (v < 5'h12) return PSC_DIV_W'(4);
    return PSC_DIV_W'({v[3:0], 1'b0});
  endfunction

  // Extended layout: mantissa [3:0], exponent split over bits 4 and [7:6].
  // Mantissa 0/1 falls back to ratio 2.
  function automatic logic [PSC_DIV_W-1:0] psc_ext_div(
    input logic [PSC_FIELD_W-1:0] f
  );
    logic [3:0] mant;
    logic [2:0] expo;
    mant = f[3:0];
    expo = {f[7:6], f[4]};
    if (mant < 4'd2) return PSC_DIV_W'(2);
    return PSC_DIV_W'(mant) << expo;
  endfunction

  // Sample-timing: upper bit selects the one-cycle late sample point.
  function automatic logic psc_late_sample(input logic [PSC_TMISO_W-1:0] t);
    return t[PSC_TMISO_W-1];
  endfunction

endpackage

// File: rtl/spi_pscl_decode.sv
module spi_pscl_decode
  import spi_pscl_pkg::*;
#(
  parameter int ENCODING = ENC_EXTENDED,
  parameter int FIELD_W  = PSC_FIELD_W,
  parameter int DIV_W    = PSC_DIV_W
) (
  input  logic [FIELD_W-1:0] field,
  output logic [DIV_W-1:0]   divisor
);

  generate
    if (ENCODING == ENC_EXTENDED) begin : g_ext
      assign divisor = DIV_W'(psc_ext_div(PSC_FIELD_W'(field)));
    end else begin : g_legacy
      assign divisor = DIV_W'(psc_legacy_div(PSC_FIELD_W'(field)));
    end
  endgenerate

endmodule

// File: rtl/spi_pscl_phase.sv
module spi_pscl_phase #(
  parameter int DIV_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cpol,
  input  logic [DIV_W-1:0] div_in,
  output logic             start,
  output logic             active,
  output logic             sck,
  output logic             lead_edge,
  output logic             trail_edge,
  output logic             cpol_q,
  output logic [DIV_W-1:0] div_q,
  output logic [DIV_W-1:0] phase_cnt
);

  logic [DIV_W-1:0] half_lo;
  logic [DIV_W-1:0] phase_len;
  logic             phase_end;
  logic             at_rest;

  assign start     = run && !active;
  // High level gets the floor half, low level the remainder.
  assign half_lo   = div_q >> 1;
  assign phase_len = sck ? half_lo : (div_q - half_lo);
  assign phase_end = (phase_cnt == phase_len - DIV_W'(1));
  assign at_rest   = (sck == cpol_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      sck        <= 1'b0;
      phase_cnt  <= '0;
      div_q      <= DIV_W'(2);
      cpol_q     <= 1'b0;
      lead_edge  <= 1'b0;
      trail_edge <= 1'b0;
    end else begin
      lead_edge  <= 1'b0;
      trail_edge <= 1'b0;
      if (!active) begin
        sck       <= cpol;
        phase_cnt <= '0;
        if (start) begin
          active <= 1'b1;
          div_q  <= div_in;
          cpol_q <= cpol;
        end
      end else if (phase_end) begin
        phase_cnt <= '0;
        if (at_rest && !run) begin
          active <= 1'b0;
        end else begin
          sck <= ~sck;
          if (at_rest) lead_edge  <= 1'b1;
          else         trail_edge <= 1'b1;
        end
      end else begin
        phase_cnt <= phase_cnt + DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/spi_pscl_strobe.sv
module spi_pscl_strobe
  import spi_pscl_pkg::*;
#(
  parameter int TMISO_W = PSC_TMISO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               cpha,
  input  logic [TMISO_W-1:0] tmiso_sel,
  input  logic               lead_edge,
  input  logic               trail_edge,
  output logic               sample_edge,
  output logic               late_q,
  output logic               launch_stb,
  output logic               sample_stb
);

  xfer_cfg_t cfg_q;
  logic      sample_dly_q;

  assign late_q      = cfg_q.late_sample;
  assign sample_edge = cfg_q.cpha ? trail_edge : lead_edge;
  assign launch_stb  = cfg_q.cpha ? lead_edge  : trail_edge;
  assign sample_stb  = cfg_q.late_sample ? sample_dly_q : sample_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q        <= '0;
      sample_dly_q <= 1'b0;
    end else begin
      sample_dly_q <= sample_edge;
      if (start) begin
        cfg_q.cpha        <= cpha;
        cfg_q.late_sample <= psc_late_sample(PSC_TMISO_W'(tmiso_sel));
      end
    end
  end

endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
  import spi_pscl_pkg::*;
#(
  parameter int ENCODING = ENC_EXTENDED,
  parameter int FIELD_W  = PSC_FIELD_W,
  parameter int DIV_W    = PSC_DIV_W,
  parameter int TMISO_W  = PSC_TMISO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [FIELD_W-1:0] prescale_field,
  input  logic [TMISO_W-1:0] tmiso_sel,
  output logic               sck,
  output logic               launch_stb,
  output logic               sample_stb
);

  localparam int CNT_W = DIV_W;

  logic [DIV_W-1:0] div_dec;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] phase_cnt;
  logic             xfer_start;
  logic             xfer_active;
  logic             lead_edge;
  logic             trail_edge;
  logic             sample_edge;
  logic             cpol_q;
  logic             late_q;

  spi_pscl_decode #(
    .ENCODING (ENCODING),
    .FIELD_W  (FIELD_W),
    .DIV_W    (DIV_W)
  ) u_decode (
    .field   (prescale_field),
    .divisor (div_dec)
  );

  spi_pscl_phase #(
    .DIV_W (CNT_W)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .cpol       (cpol),
    .div_in     (div_dec),
    .start      (xfer_start),
    .active     (xfer_active),
    .sck        (sck),
    .lead_edge  (lead_edge),
    .trail_edge (trail_edge),
    .cpol_q     (cpol_q),
    .div_q      (div_q),
    .phase_cnt  (phase_cnt)
  );

  spi_pscl_strobe #(
    .TMISO_W (TMISO_W)
  ) u_strobe (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (xfer_start),
    .cpha        (cpha),
    .tmiso_sel   (tmiso_sel),
    .lead_edge   (lead_edge),
    .trail_edge  (trail_edge),
    .sample_edge (sample_edge),
    .late_q      (late_q),
    .launch_stb  (launch_stb),
    .sample_stb  (sample_stb)
  );

endmodule

// File: rtl/spi_sck_prescaler_chk.sv
module spi_sck_prescaler_chk #(
  parameter int DIV_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpol,
  input logic             sck,
  input logic             xfer_active,
  input logic             lead_edge,
  input logic             trail_edge,
  input logic             sample_edge,
  input logic             sample_stb,
  input logic             cpol_q,
  input logic             late_q,
  input logic [DIV_W-1:0] div_q,
  input logic [DIV_W-1:0] phase_cnt
);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_IDLE_AT_CPOL: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(!xfer_active)) |-> (sck == $past(cpol))); // R7

  AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active |-> (div_q >= DIV_W'(2))); // R5

  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && xfer_active && $past(xfer_active)) |-> $stable(div_q)); // R8

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active |-> (phase_cnt < div_q)); // R6

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_edge, trail_edge})); // R9

  AST_LEAD_LEAVES_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && lead_edge) |-> (sck != cpol_q && $past(sck) == cpol_q)); // R9

  AST_LATE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && late_q && sample_stb) |-> $past(sample_edge)); // R10

  AST_STOP_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(xfer_active)) |-> (sck == cpol_q)); // R11

endmodule

bind spi_sck_prescaler spi_sck_prescaler_chk #(.DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpol        (cpol),
  .sck         (sck),
  .xfer_active (xfer_active),
  .lead_edge   (lead_edge),
  .trail_edge  (trail_edge),
  .sample_edge (sample_edge),
  .sample_stb  (sample_stb),
  .cpol_q      (cpol_q),
  .late_q      (late_q),
  .div_q       (div_q),
  .phase_cnt   (phase_cnt)
);

// File: tb/spi_sck_prescaler_tb_top.sv
module spi_sck_prescaler_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       run;
  logic       cpol;
  logic       cpha;
  logic [7:0] field;
  logic [1:0] tmiso;
  logic       sck_e, launch_e, sample_e;
  logic       sck_l, launch_l, sample_l;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  spi_sck_prescaler #(.ENCODING(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .cpol(cpol), .cpha(cpha),
    .prescale_field(field), .tmiso_sel(tmiso),
    .sck(sck_e), .launch_stb(launch_e), .sample_stb(sample_e)
  );

  spi_sck_prescaler #(.ENCODING(0)) dut_leg_i (
    .clk(clk), .rst_n(rst_n), .run(run), .cpol(cpol), .cpha(cpha),
    .prescale_field(field), .tmiso_sel(tmiso),
    .sck(sck_l), .launch_stb(launch_l), .sample_stb(sample_l)
  );

  function automatic logic get_sck(input bit ext);
    return ext ? sck_e : sck_l;
  endfunction

  function automatic int exp_leg(input int f);
    int v = f & 31;
    if (v < 18) return 4;
    return (v - 16) * 2;
  endfunction

  function automatic int exp_ext(input int f);
    int m = f & 15;
    int e = (((f >> 6) & 3) * 2) + ((f >> 4) & 1);
    if (m < 2) return 2;
    return m * (1 << e);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic count_level(input bit ext, output int n);
    logic lv;
    lv = get_sck(ext);
    n = 0;
    while (get_sck(ext) == lv && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic measure(input bit ext, output int hi, output int lo);
    logic prev, la;
    int a, b, g;
    prev = get_sck(ext);
    g = 0;
    while (get_sck(ext) == prev && g < 5000) begin
      g++;
      @(negedge clk);
    end
    la = get_sck(ext);
    count_level(ext, a);
    count_level(ext, b);
    hi = la ? a : b;
    lo = la ? b : a;
  endtask

  task automatic stop_and_settle(input int div);
    run = 1'b0;
    repeat (2 * div + 8) @(negedge clk);
  endtask

  // R2..R6: ratio and duty for one field value in both layouts.
  task automatic div_case(input logic [7:0] f, input logic pol, input string req);
    int hi, lo, de, dl;
    de = exp_ext(int'(f));
    dl = exp_leg(int'(f));
    @(negedge clk);
    field = f; cpol = pol; run = 1'b1;
    measure(1'b1, hi, lo);
    chk(req, $sformatf("ext field %02h high", f), hi, de / 2);
    chk(req, $sformatf("ext field %02h low", f), lo, de - de / 2);
    measure(1'b0, hi, lo);
    chk(req, $sformatf("legacy field %02h high", f), hi, dl / 2);
    chk(req, $sformatf("legacy field %02h low", f), lo, dl - dl / 2);
    stop_and_settle(de > dl ? de : dl);
  endtask

  task automatic test_reset;  // R1
    rst_n = 1'b0; run = 1'b0; cpol = 1'b0; cpha = 1'b0;
    field = 8'h12; tmiso = 2'd1;
    repeat (4) @(negedge clk);
    chk("R1", "sck in reset", int'(sck_e) + int'(sck_l), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "sck after reset", int'(sck_e) + int'(sck_l), 0);
    chk("R1", "strobes after reset",
        int'(launch_e) + int'(sample_e) + int'(launch_l) + int'(sample_l), 0);
  endtask

  task automatic test_idle_level;  // R7
    @(negedge clk); cpol = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7", "idle sck follows cpol=1", int'(sck_e) + int'(sck_l), 2);
    cpol = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7", "idle sck follows cpol=0", int'(sck_e) + int'(sck_l), 0);
  endtask

  task automatic test_hold_divisor;  // R8
    int hi, lo;
    @(negedge clk);
    field = 8'h16; cpol = 1'b0; run = 1'b1;
    repeat (3) @(negedge clk);
    field = 8'h1A;
    measure(1'b1, hi, lo);
    chk("R8", "ext ratio held after field change", hi + lo, 12);
    measure(1'b0, hi, lo);
    chk("R8", "legacy ratio held after field change", hi + lo, 12);
    stop_and_settle(20);
    run = 1'b1;
    measure(1'b1, hi, lo);
    chk("R8", "ext new ratio at next transfer", hi + lo, 20);
    measure(1'b0, hi, lo);
    chk("R8", "legacy new ratio at next transfer", hi + lo, 20);
    stop_and_settle(20);
  endtask

  // R9/R10: strobe placement against observed SCK edges.
  task automatic strobe_case(input logic ph, input logic [1:0] tm, input bit late,
                             input string req);
    logic pe, pl, ce, cl;
    bit   se_e_prev, se_l_prev;
    int   bad, edges;
    @(negedge clk);
    field = 8'h04; cpol = 1'b0; cpha = ph; tmiso = tm; run = 1'b1;
    pe = sck_e; pl = sck_l;
    se_e_prev = 0; se_l_prev = 0;
    bad = 0; edges = 0;
    for (int i = 0; i < 40; i++) begin
      bit lead_e, trail_e, lead_l, trail_l, se_e, se_l;
      @(negedge clk);
      ce = sck_e; cl = sck_l;
      lead_e  = (ce != pe) && (ce != cpol);
      trail_e = (ce != pe) && (ce == cpol);
      lead_l  = (cl != pl) && (cl != cpol);
      trail_l = (cl != pl) && (cl == cpol);
      se_e = ph ? trail_e : lead_e;
      se_l = ph ? trail_l : lead_l;
      if (launch_e != (ph ? lead_e : trail_e)) bad++;
      if (launch_l != (ph ? lead_l : trail_l)) bad++;
      if (sample_e != (late ? se_e_prev : se_e)) bad++;
      if (sample_l != (late ? se_l_prev : se_l)) bad++;
      if (lead_e) edges++;
      se_e_prev = se_e; se_l_prev = se_l;
      pe = ce; pl = cl;
    end
    chk(req, $sformatf("strobe mismatches cpha=%0d tm=%0d", ph, tm), bad, 0);
    chk(req, $sformatf("leading edges seen cpha=%0d tm=%0d", ph, tm), edges > 5 ? 1 : 0, 1);
    stop_and_settle(4);
    cpha = 1'b0; tmiso = 2'd1;
  endtask

  task automatic test_stop;  // R11
    int changes;
    logic pe, pl;
    @(negedge clk);
    field = 8'h0F; cpol = 1'b1; run = 1'b1;
    repeat (37) @(negedge clk);
    run = 1'b0;
    repeat (40) @(negedge clk);
    chk("R11", "sck at rest after stop", int'(sck_e) + int'(sck_l), 2);
    changes = 0; pe = sck_e; pl = sck_l;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sck_e != pe || sck_l != pl) changes++;
      pe = sck_e; pl = sck_l;
    end
    chk("R11", "no toggles after stop", changes, 0);
    // Request dropped before the first leading edge.
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    changes = 0; pe = sck_e; pl = sck_l;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sck_e != pe || sck_l != pl) changes++;
      pe = sck_e; pl = sck_l;
    end
    chk("R11", "short request gives no edge", changes, 0);
    cpol = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    div_case(8'h12, 1'b0, "R2");
    div_case(8'h1F, 1'b0, "R2");
    div_case(8'h17, 1'b0, "R2");
    div_case(8'h05, 1'b0, "R3");
    div_case(8'hF3, 1'b0, "R3");
    div_case(8'h95, 1'b0, "R4");
    div_case(8'hB5, 1'b0, "R4");
    div_case(8'hDF, 1'b0, "R4");
    div_case(8'h00, 1'b0, "R5");
    div_case(8'hD0, 1'b0, "R5");
    div_case(8'h11, 1'b0, "R5");
    div_case(8'h03, 1'b0, "R6");
    div_case(8'h0F, 1'b0, "R6");
    div_case(8'h03, 1'b1, "R6");
    test_idle_level();
    test_hold_divisor();
    strobe_case(1'b0, 2'd1, 1'b0, "R9");
    strobe_case(1'b1, 2'd1, 1'b0, "R9");
    strobe_case(1'b0, 2'd2, 1'b1, "R10");
    strobe_case(1'b1, 2'd3, 1'b1, "R10");
    strobe_case(1'b0, 2'd0, 1'b0, "R10");
    test_stop();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule